// File: doc/BRIEF.md
# Remote Atomic Memory Update Engine

This block applies atomic read-modify-write updates, delivered by the network as requests, to a small word-addressed memory held inside the block. Each request carries a word address, an opcode, one or two operands, a fetch flag, a tag, a packet sequence number and two flags that mark the first and the last update of the packet it came from. The engine reads the addressed word, computes the new value, writes it back and, when the fetch flag is set, returns the value the word held before the update, together with the tag, on a response channel.

One update is in flight at a time. A request is accepted only when the engine is idle, and the engine stays busy until the write has landed and any response has been taken, so consecutive updates to one word always see each other's results. Several updates from one packet are applied in arrival order. To give exactly-once semantics when a sender retries, the engine remembers the sequence number of the last packet it completed; a packet that starts with that same number is treated as a retransmission and all of its updates are discarded.

Top module: `rmw_atomic_engine`

## Requirements
- R1: Opcode 0 (add) stores the old word plus operand A, truncated to the word width (wraps modulo 2^DW).
- R2: Opcodes 1, 2 and 3 store the bitwise AND, OR and XOR respectively of the old word and operand A.
- R3: Opcode 4 (compare-and-swap) stores operand B only when the old word equals operand A, otherwise leaves the word unchanged; its response carries a success bit set exactly when the store took place. The success bit is zero for every other opcode.
- R4: With the fetch flag set, exactly one response is produced, carrying the request tag and the pre-update word; with the fetch flag clear, the update is applied and no response is produced.
- R5: A compare-and-swap with fetch returns the pre-update word whether or not the swap took place.
- R6: After a request is accepted, no further request is accepted until its write is done and its response (if any) has been taken, so a following update to the same word observes the result of the earlier one.
- R7: The updates of one packet (first flag on the opening one, last flag on the closing one) are each applied in the order they arrive.
- R8: A packet whose first update carries the same sequence number as the last completed packet is a duplicate: none of its updates changes memory and none produces a response.
- R9: While a response is pending and the response ready input is low, the response stays valid with unchanged tag, data and success bit, and no request is accepted.
- R10: After reset every word reads as zero, no response is pending and the request ready output is high.
- R11: Opcodes 5, 6 and 7 are reserved: the word is left unchanged and a fetch returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Engine can accept a request |
| in_addr | input | AW | Word address |
| in_op | input | 3 | Opcode (0 add, 1 and, 2 or, 3 xor, 4 compare-and-swap, 5-7 reserved) |
| in_opa | input | DW | Operand A, or compare value for compare-and-swap |
| in_opb | input | DW | Swap value for compare-and-swap |
| in_fetch | input | 1 | Return the pre-update word |
| in_tag | input | TW | Request tag echoed in the response |
| in_seq | input | SW | Packet sequence number |
| in_first | input | 1 | First update of its packet |
| in_last | input | 1 | Last update of its packet |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_tag | output | TW | Tag of the request answered |
| rsp_data | output | DW | Word value before the update |
| rsp_cas_ok | output | 1 | Compare-and-swap stored its value |

## Verification
The bench builds the engine with an 8-bit word, eight words of storage, 4-bit tags and 4-bit sequence numbers. The narrow word lets a sweep of every opcode over every address hit additive wrap-around and both compare-and-swap outcomes frequently, with a bench-side shadow memory giving the expected old and new values arithmetically. The small sequence space lets a retransmitted packet, a multi-update packet and response back-pressure each be exercised in a few dozen cycles.

// File: rtl/rmw_atomic_engine.sv
module rmw_atomic_engine #(
  parameter int DW = 64,
  parameter int AW = 4,
  parameter int TW = 4,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic [2:0]    in_op,
  input  logic [DW-1:0] in_opa,
  input  logic [DW-1:0] in_opb,
  input  logic          in_fetch,
  input  logic [TW-1:0] in_tag,
  input  logic [SW-1:0] in_seq,
  input  logic          in_first,
  input  logic          in_last,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [TW-1:0] rsp_tag,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_cas_ok
);
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_AND = 3'd1;
  localparam logic [2:0] OP_OR  = 3'd2;
  localparam logic [2:0] OP_XOR = 3'd3;
  localparam logic [2:0] OP_CAS = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_RSP} state_t;
  state_t state;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] q_addr;
  logic [2:0]    q_op;
  logic [DW-1:0] q_opa, q_opb;
  logic          q_fetch, q_last, q_dup;
  logic [TW-1:0] q_tag;
  logic [SW-1:0] q_seq, done_seq;
  logic          done_seen;

  logic [DW-1:0] old_w, new_w;
  logic          cas_hit;

  assign in_ready  = (state == S_IDLE);
  assign rsp_valid = (state == S_RSP);
  assign old_w     = mem[q_addr];
  assign cas_hit   = (old_w == q_opa);

  always_comb begin
    case (q_op)
      OP_ADD:  new_w = old_w + q_opa;
      OP_AND:  new_w = old_w & q_opa;
      OP_OR:   new_w = old_w | q_opa;
      OP_XOR:  new_w = old_w ^ q_opa;
      OP_CAS:  new_w = cas_hit ? q_opb : old_w;
      default: new_w = old_w;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      q_addr     <= '0;
      q_op       <= '0;
      q_opa      <= '0;
      q_opb      <= '0;
      q_fetch    <= 1'b0;
      q_last     <= 1'b0;
      q_dup      <= 1'b0;
      q_tag      <= '0;
      q_seq      <= '0;
      done_seq   <= '0;
      done_seen  <= 1'b0;
      rsp_tag    <= '0;
      rsp_data   <= '0;
      rsp_cas_ok <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      case (state)
        S_IDLE: if (in_valid) begin
          q_addr  <= in_addr;
          q_op    <= in_op;
          q_opa   <= in_opa;
          q_opb   <= in_opb;
          q_fetch <= in_fetch;
          q_last  <= in_last;
          q_tag   <= in_tag;
          q_seq   <= in_seq;
          if (in_first) q_dup <= done_seen && (in_seq == done_seq);
          state   <= S_EXEC;
        end
        S_EXEC: begin
          if (!q_dup) begin
            mem[q_addr] <= new_w;
            rsp_data    <= old_w;
            rsp_tag     <= q_tag;
            rsp_cas_ok  <= (q_op == OP_CAS) && cas_hit;
            if (q_last) begin
              done_seq  <= q_seq;
              done_seen <= 1'b1;
            end
          end
          state <= (q_fetch && !q_dup) ? S_RSP : S_IDLE;
        end
        S_RSP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_tag) && $stable(rsp_cas_ok));

  a_r9_no_accept_while_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !in_ready);

  a_r6_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  a_r8_dup_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXEC) && q_dup |=> !rsp_valid);

  a_r3_cas_miss_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXEC) && (q_op == OP_CAS) && !cas_hit |=> mem[$past(q_addr)] == $past(old_w));

  a_r3_cas_ok_only_cas: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXEC) && !q_dup && (q_op != OP_CAS) |=> !rsp_cas_ok);
endmodule

// File: tb/rmw_atomic_engine_tb.sv
module rmw_atomic_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int TW = 4;
  localparam int SW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [AW-1:0] in_addr = '0;
  logic [2:0] in_op = '0;
  logic [DW-1:0] in_opa = '0, in_opb = '0;
  logic in_fetch = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [TW-1:0] in_tag = '0;
  logic [SW-1:0] in_seq = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [TW-1:0] rsp_tag;
  logic [DW-1:0] rsp_data;
  logic rsp_cas_ok;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  logic [SW-1:0] seq_n = '0;
  logic [TW-1:0] tag_n = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rmw_atomic_engine #(.DW(DW), .AW(AW), .TW(TW), .SW(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_op(in_op), .in_opa(in_opa), .in_opb(in_opb),
    .in_fetch(in_fetch), .in_tag(in_tag), .in_seq(in_seq),
    .in_first(in_first), .in_last(in_last), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .rsp_cas_ok(rsp_cas_ok));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model(input logic [2:0] op, input logic [DW-1:0] old,
                                          input logic [DW-1:0] a, input logic [DW-1:0] b);
    case (op)
      3'd0: return old + a;
      3'd1: return old & a;
      3'd2: return old | a;
      3'd3: return old ^ a;
      3'd4: return (old == a) ? b : old;
      default: return old;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1, 3'd2, 3'd3: return "R2";
      3'd4: return "R3/R5";
      default: return "R11";
    endcase
  endfunction

  task automatic send(input logic [AW-1:0] a, input logic [2:0] op, input logic [DW-1:0] x,
                      input logic [DW-1:0] y, input bit f, input logic [SW-1:0] s,
                      input bit first, input bit last);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_addr = a; in_op = op; in_opa = x; in_opb = y; in_fetch = f;
    in_tag = tag_n; in_seq = s; in_first = first; in_last = last;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_rsp(output bit got);
    got = 1'b0;
    for (int k = 0; k < 6; k++) begin
      if (rsp_valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic no_rsp(input string req);
    bit seen = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (rsp_valid) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, req, seen, 0);
  endtask

  task automatic atomic(input logic [AW-1:0] a, input logic [2:0] op, input logic [DW-1:0] x,
                        input logic [DW-1:0] y, input bit f, input logic [SW-1:0] s,
                        input bit first, input bit last, input string req);
    logic [DW-1:0] old;
    bit got;
    old = ref_mem[a];
    ref_mem[a] = model(op, old, x, y);
    send(a, op, x, y, f, s, first, last);
    if (f) begin
      wait_rsp(got);
      chk(got, {req, " R4 response present"}, got, 1);
      chk(rsp_data == old, {req, " old value"}, rsp_data, old);
      chk(rsp_tag == tag_n, {req, " R4 tag"}, rsp_tag, tag_n);
      chk(rsp_cas_ok == (op == 3'd4 && old == x), {req, " R3 success bit"},
          rsp_cas_ok, (op == 3'd4 && old == x));
      @(negedge clk);
    end else begin
      no_rsp({req, " R4 no response without fetch"});
    end
    tag_n++;
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      atomic(a[AW-1:0], 3'd2, '0, '0, 1'b1, seq_n, 1'b1, 1'b1, req);
      seq_n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    bit got;
    for (int a = 0; a < DEPTH; a++) ref_mem[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 ready after reset", in_ready, 1);
    chk(rsp_valid == 1'b0, "R10 no response after reset", rsp_valid, 0);
    read_all("R10 zero after reset");

    for (int a = 0; a < DEPTH; a++) begin
      for (int i = 0; i < 24; i++) begin
        logic [2:0] op;
        logic [DW-1:0] x, y;
        op = 3'(i + a);
        x = 8'(i * 53 + a * 29 + 7);
        y = 8'(i * 91 + a * 13 + 200);
        if (op == 3'd4 && i[1]) x = ref_mem[a];
        atomic(a[AW-1:0], op, x, y, (i % 4) != 3, seq_n, 1'b1, 1'b1, req_of(op));
        seq_n++;
      end
    end
    read_all("R2 R4 final contents after sweep");

    atomic(3'd1, 3'd4, ref_mem[1], 8'hFF, 1'b1, seq_n, 1'b1, 1'b1, "R3 cas set");
    seq_n++;
    atomic(3'd1, 3'd0, 8'h02, '0, 1'b1, seq_n, 1'b1, 1'b1, "R1 wrap");
    seq_n++;
    chk(ref_mem[1] == 8'h01, "R1 wrap model", ref_mem[1], 1);
    atomic(3'd1, 3'd4, 8'h77, 8'h33, 1'b1, seq_n, 1'b1, 1'b1, "R5 cas miss returns old");
    seq_n++;

    atomic(3'd2, 3'd0, 8'h01, '0, 1'b1, seq_n, 1'b1, 1'b0, "R7 R6 pkt part 1");
    atomic(3'd2, 3'd3, 8'h0F, '0, 1'b1, seq_n, 1'b0, 1'b0, "R7 R6 pkt part 2");
    atomic(3'd2, 3'd0, 8'h10, '0, 1'b1, seq_n, 1'b0, 1'b1, "R7 R6 pkt part 3");

    send(3'd2, 3'd0, 8'h55, '0, 1'b1, seq_n, 1'b1, 1'b0);
    no_rsp("R8 duplicate first update silent");
    tag_n++;
    send(3'd3, 3'd3, 8'hA5, '0, 1'b1, seq_n, 1'b0, 1'b1);
    no_rsp("R8 duplicate last update silent");
    tag_n++;
    seq_n++;
    atomic(3'd2, 3'd2, '0, '0, 1'b1, seq_n, 1'b1, 1'b1, "R8 word unchanged by duplicate");
    seq_n++;
    atomic(3'd3, 3'd2, '0, '0, 1'b1, seq_n, 1'b1, 1'b1, "R8 second word unchanged");
    seq_n++;

    rsp_ready = 1'b0;
    held = ref_mem[5];
    ref_mem[5] = held + 8'h03;
    send(3'd5, 3'd0, 8'h03, '0, 1'b1, seq_n, 1'b1, 1'b1);
    seq_n++;
    wait_rsp(got);
    chk(got, "R9 response raised", got, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rsp_valid == 1'b1, "R9 response held", rsp_valid, 1);
      chk(rsp_data == held, "R9 data held", rsp_data, held);
      chk(rsp_tag == tag_n, "R9 tag held", rsp_tag, tag_n);
      chk(in_ready == 1'b0, "R9 R6 no accept while pending", in_ready, 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 response consumed", rsp_valid, 0);
    tag_n++;
    atomic(3'd5, 3'd2, '0, '0, 1'b1, seq_n, 1'b1, 1'b1, "R9 R6 update landed once");
    seq_n++;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule